// File: doc/BRIEF.md
# Per-Pin Programmable External Interrupt Trigger

This block turns six external interrupt request lines into request outputs for an interrupt controller. Every line has its own two-bit trigger selection. The selection can make the line sense a low level, or detect a rising edge, a falling edge, or an edge in either direction. A line is first brought into the system clock domain through a two-stage synchronizer. It is then compared with its value from the previous cycle to find edges.

In the edge modes a detected edge sets a sticky pending flag. The flag holds the request until software writes a one to the matching bit of the flag address. In low-level mode the request simply mirrors the synchronized pin: it is active while the pin is low. The trigger selections live in one 16-bit register behind a small read/write bus port. The flag address reads back the current request vector. The outputs feed a downstream priority and vectoring stage.

Top module: `irq_trigger_unit`

## Requirements
- R1: After reset the mode register reads 0x0000. With all pins held high, `irq_req` is 0 on every pin.
- R2: Line n's trigger field is mode register bits [2n+1:2n]. Bits 11:0 are read/write at bus address 0. Trigger encodings: 00 low level, 01 either edge, 10 falling edge, 11 rising edge.
- R3: Bits 15:12 of the mode register always read as zero, whatever value was written.
- R4: In trigger code 00, `irq_req[n]` is 1 while the synchronized pin is low and 0 while it is high, with no latching. Entering code 00 discards any pending flag.
- R5: In trigger code 01, both a rising and a falling transition of the pin set the pending flag of that line.
- R6: In trigger code 10, a falling transition sets the pending flag. A rising transition does not.
- R7: In trigger code 11, a rising transition sets the pending flag. A falling transition does not.
- R8: In the edge codes, `irq_req[n]` stays set until a bus write to address 1 carries a one in bit n. Zero bits in that write leave their lines untouched.
- R9: A read at address 1 returns `irq_req` in bits 5:0 and zeros above.
- R10: A write that changes a line's trigger field never sets that line's pending flag by itself. This holds even when the pin level, seen by the old code, would look like an asserted request.
- R11: When an edge event and a clear write for the same line land in the same cycle, the pending flag remains set.
- R12: Each line follows only its own field and pin. Activity on one line changes no other line's request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 6 | Raw external interrupt lines, asynchronous to clk |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = mode register, 1 = flag register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| irq_req | output | 6 | Per-line interrupt request |

## Verification
The bench drives a new edge in the same cycle as a clear write for that line. A design that let the clear win would silently lose the second interrupt. It switches a line from low-level mode to falling-edge mode while the pin sits low. An implementation that recomputed history from the old mode would report a phantom request there. It checks that a falling edge is ignored in rising-only mode and the reverse, which catches swapped encodings or inverted comparisons. It also checks that clearing one flag, or writing zeros, spares the other lines, which exposes a clear that is applied to the whole register.

// File: rtl/irqt_pkg.sv
package irqt_pkg;

    localparam int IRQT_LINES  = 6;
    localparam int IRQT_BUS_W  = 16;
    localparam int IRQT_SYNC_N = 2;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_BOTH = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_RISE = 2'b11
    } trig_mode_e;

    localparam logic ADDR_MODE = 1'b0;
    localparam logic ADDR_FLAG = 1'b1;

endpackage

// File: rtl/irqt_sync.sv
module irqt_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/irqt_detect.sv
module irqt_detect
    import irqt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_in,
    input  logic [1:0] mode,
    input  logic       mode_chg,
    input  logic       clr,
    output logic       req
);
    typedef struct packed {
        logic prev;
        logic pend;
    } det_t;

    det_t s_d, s_q;
    logic rise, fall, hit;

    always_comb begin
        rise = sync_in & ~s_q.prev;
        fall = ~sync_in & s_q.prev;
        case (trig_mode_e'(mode))
            TRIG_BOTH: hit = rise | fall;
            TRIG_FALL: hit = fall;
            TRIG_RISE: hit = rise;
            default:   hit = 1'b0;
        endcase
        // A mode rewrite re-arms the comparison instead of producing an event.
        if (mode_chg) hit = 1'b0;

        s_d      = s_q;
        s_d.prev = sync_in;
        if (trig_mode_e'(mode) == TRIG_LOW) s_d.pend = 1'b0;
        else if (hit)                       s_d.pend = 1'b1;
        else if (clr)                       s_d.pend = 1'b0;

        req = (trig_mode_e'(mode) == TRIG_LOW) ? ~sync_in : s_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{prev: 1'b1, pend: 1'b0};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/irqt_regs.sv
module irqt_regs
    import irqt_pkg::*;
#(
    parameter int NPIN  = 6,
    parameter int REG_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic                 bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    input  logic [NPIN-1:0]      req_bits,
    output logic [NPIN-1:0][1:0] mode,
    output logic [NPIN-1:0]      mode_chg,
    output logic [NPIN-1:0]      clr,
    output logic [REG_W-1:0]     bus_rdata
);
    localparam int FIELD_BITS = 2 * NPIN;

    typedef struct packed {
        logic [FIELD_BITS-1:0] mode;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_mode, wr_flag;
    logic  unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[REG_W-1:FIELD_BITS];

    always_comb begin
        wr_mode = bus_sel && bus_wr && (bus_addr == ADDR_MODE);
        wr_flag = bus_sel && bus_wr && (bus_addr == ADDR_FLAG);

        r_d = r_q;
        if (wr_mode) r_d.mode = bus_wdata[FIELD_BITS-1:0];

        for (int i = 0; i < NPIN; i++) begin
            mode[i]     = r_q.mode[2*i +: 2];
            mode_chg[i] = wr_mode && (bus_wdata[2*i +: 2] != r_q.mode[2*i +: 2]);
            clr[i]      = wr_flag && bus_wdata[i];
        end

        bus_rdata = '0;
        if (bus_addr == ADDR_MODE) bus_rdata[FIELD_BITS-1:0] = r_q.mode;
        else                       bus_rdata[NPIN-1:0]       = req_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/irq_trigger_unit.sv
module irq_trigger_unit
    import irqt_pkg::*;
#(
    parameter int NPIN   = IRQT_LINES,
    parameter int REG_W  = IRQT_BUS_W,
    parameter int SYNC_N = IRQT_SYNC_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPIN-1:0]  irq_pin,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic [NPIN-1:0]  irq_req
);
    logic [NPIN-1:0]      pin_sync;
    logic [NPIN-1:0][1:0] mode_w;
    logic [NPIN-1:0]      chg_w;
    logic [NPIN-1:0]      clr_w;

    irqt_sync #(.W(NPIN), .STAGES(SYNC_N)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (irq_pin),
        .dout (pin_sync)
    );

    irqt_regs #(.NPIN(NPIN), .REG_W(REG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .req_bits (irq_req),
        .mode     (mode_w),
        .mode_chg (chg_w),
        .clr      (clr_w),
        .bus_rdata(bus_rdata)
    );

    for (genvar g = 0; g < NPIN; g++) begin : g_line
        irqt_detect u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .sync_in (pin_sync[g]),
            .mode    (mode_w[g]),
            .mode_chg(chg_w[g]),
            .clr     (clr_w[g]),
            .req     (irq_req[g])
        );
    end
endmodule

// File: rtl/irqt_checker.sv
module irqt_checker
    import irqt_pkg::*;
#(
    parameter int NPIN  = 6,
    parameter int REG_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NPIN-1:0]      irq_pin,
    input logic                 bus_addr,
    input logic [REG_W-1:0]     bus_rdata,
    input logic [NPIN-1:0]      irq_req,
    input logic [NPIN-1:0][1:0] mode,
    input logic [NPIN-1:0]      chg,
    input logic [NPIN-1:0]      clr
);
    logic [1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    AST_MODE_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_MODE) |-> (bus_rdata[REG_W-1:2*NPIN] == '0)); // R3

    AST_FLAG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_FLAG) |-> (bus_rdata == REG_W'(irq_req))); // R9

    for (genvar i = 0; i < NPIN; i++) begin : g_chk
        AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[i] != TRIG_LOW && irq_req[i] && !clr[i] && !chg[i]) |=> irq_req[i]); // R8

        AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc == 2'd3 && mode[i] == TRIG_LOW) |-> (irq_req[i] == !$past(irq_pin[i], 2))); // R4

        AST_CHG_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (chg[i] && mode[i] != TRIG_LOW && !irq_req[i]) |=> !irq_req[i] || mode[i] == TRIG_LOW); // R10
    end
endmodule

bind irq_trigger_unit irqt_checker #(.NPIN(NPIN), .REG_W(REG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_pin  (irq_pin),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .irq_req  (irq_req),
    .mode     (mode_w),
    .chg      (chg_w),
    .clr      (clr_w)
);

// File: tb/sim_irq_trigger_unit.sv
`timescale 1ns/1ps
module sim_irq_trigger_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  irq_pin = 6'h3F;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [5:0]  irq_req;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    irq_trigger_unit u0 (
        .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic drive_pin(input int n, input logic v);
        @(negedge clk);
        irq_pin[n] = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic fresh();
        irq_pin = 6'h3F;
        repeat (3) @(negedge clk);
        bus_write(1'b0, 16'h0000);
        bus_write(1'b1, 16'h003F);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        bus_read(1'b0, d);
        chk("R1 mode after reset", d, 16'h0000);
        chk("R1 req after reset", 16'(irq_req), 16'h0000);
    endtask

    task automatic t_mode_rw();
        logic [15:0] d;
        bus_write(1'b0, 16'hFFFF);
        bus_read(1'b0, d);
        chk("R3 upper bits read zero", d, 16'h0FFF);
        bus_write(1'b0, 16'hA5C3);
        bus_read(1'b0, d);
        chk("R2 mode readback", d, 16'h05C3);
        fresh();
    endtask

    task automatic t_level();
        logic [15:0] d;
        fresh();
        drive_pin(2, 1'b0);
        chk("R4 level low asserts", 16'(irq_req), 16'h0004);
        bus_read(1'b1, d);
        chk("R9 flag read", d, 16'h0004);
        drive_pin(2, 1'b1);
        chk("R4 level not latched", 16'(irq_req), 16'h0000);
        bus_write(1'b0, 16'h0003);
        drive_pin(0, 1'b0);
        drive_pin(0, 1'b1);
        chk("R7 rise sets pending", 16'(irq_req), 16'h0001);
        bus_write(1'b0, 16'h0000);
        chk("R4 level mode pin high", 16'(irq_req), 16'h0000);
        bus_write(1'b0, 16'h0003);
        @(negedge clk);
        chk("R4 pending discarded", 16'(irq_req), 16'h0000);
    endtask

    task automatic t_both();
        fresh();
        bus_write(1'b0, 16'h0004);
        drive_pin(1, 1'b0);
        chk("R5 falling in either-edge", 16'(irq_req), 16'h0002);
        bus_write(1'b1, 16'h0002);
        @(negedge clk);
        chk("R8 clear with pin stable", 16'(irq_req), 16'h0000);
        drive_pin(1, 1'b1);
        chk("R5 rising in either-edge", 16'(irq_req), 16'h0002);
    endtask

    task automatic t_fall();
        fresh();
        bus_write(1'b0, 16'h0200);
        drive_pin(4, 1'b0);
        chk("R6 falling sets", 16'(irq_req), 16'h0010);
        bus_write(1'b1, 16'h0010);
        drive_pin(4, 1'b1);
        chk("R6 rising ignored", 16'(irq_req), 16'h0000);
    endtask

    task automatic t_rise_clear();
        fresh();
        bus_write(1'b0, 16'h0C00);
        drive_pin(5, 1'b0);
        chk("R7 falling ignored", 16'(irq_req), 16'h0000);
        drive_pin(5, 1'b1);
        chk("R7 rising sets", 16'(irq_req), 16'h0020);
        repeat (4) @(negedge clk);
        chk("R8 pending holds", 16'(irq_req), 16'h0020);
        bus_write(1'b1, 16'h0000);
        chk("R8 zero write no effect", 16'(irq_req), 16'h0020);
        bus_write(1'b1, 16'h0010);
        chk("R8 other bit clear no effect", 16'(irq_req), 16'h0020);
        bus_write(1'b1, 16'h0020);
        chk("R8 own bit clears", 16'(irq_req), 16'h0000);
    endtask

    task automatic t_modechg();
        fresh();
        drive_pin(0, 1'b0);
        chk("R4 level low before switch", 16'(irq_req), 16'h0001);
        bus_write(1'b0, 16'h0002);
        repeat (3) @(negedge clk);
        chk("R10 switch to falling no event", 16'(irq_req), 16'h0000);
        bus_write(1'b0, 16'h0001);
        repeat (3) @(negedge clk);
        chk("R10 switch to either-edge no event", 16'(irq_req), 16'h0000);
    endtask

    task automatic t_race();
        fresh();
        bus_write(1'b0, 16'h00C0);
        drive_pin(3, 1'b0);
        drive_pin(3, 1'b1);
        chk("R7 pin3 rising sets", 16'(irq_req), 16'h0008);
        drive_pin(3, 1'b0);
        @(negedge clk);
        irq_pin[3] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 16'h0008;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 set beats clear", 16'(irq_req), 16'h0008);
        bus_write(1'b1, 16'h0008);
        chk("R8 later clear works", 16'(irq_req), 16'h0000);
    endtask

    task automatic t_indep();
        fresh();
        bus_write(1'b0, 16'h000B);
        drive_pin(1, 1'b0);
        chk("R12 only line1 requests", 16'(irq_req), 16'h0002);
        drive_pin(2, 1'b0);
        chk("R12 line2 level adds", 16'(irq_req), 16'h0006);
        drive_pin(0, 1'b0);
        chk("R12 line0 falling ignored", 16'(irq_req), 16'h0006);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_mode_rw();
        t_level();
        t_both();
        t_fall();
        t_rise_clear();
        t_modechg();
        t_race();
        t_indep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule